// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block lets an 8-bit host processor reach two targets inside a peripheral: a register file and a 64 KB buffer-memory window. A static strap input chooses how the two host control pins are read. Strapped high, they are separate active-low read and write strobes. Strapped low, one pin is a read/write status and the other is an active-low data strobe. Two active-low chip selects pick the target. If both are active, the register file wins.

Addressing can be split or multiplexed. With the address-latch strobe held low, the 16-bit address comes from two dedicated address byte inputs. Once a latch strobe has been seen, the low address byte comes from the shared 8-bit address/data bus, captured while the strobe is high. The upper byte still comes from its own input. All host inputs pass through two-flop synchronizers into the core clock. Each host access becomes exactly one single-cycle request on a synchronous core port, and read data returns one cycle after that request.

For reads, the block drives the captured data onto the shared bus. It can also drive a tri-stateable ready pin, which is enabled by a configuration input. The host reset is filtered so that a one-clock glitch is ignored, and the filtered reset is provided to the core.

Top module: `hostbus_top`

## Requirements
- R1: With cpu_sel = 1, ctl_b low with ctl_a high is a read and ctl_a low with ctl_b high is a write.
- R2: With cpu_sel = 0, ctl_b low is the data strobe, and ctl_a gives the direction (1 = read, 0 = write).
- R3: An access with only cs_reg_n low raises core_reg_req. An access with only cs_mem_n low raises core_mem_req. With both low, only core_reg_req rises, and the two request outputs are never high together.
- R4: Before any latch strobe, core_addr = {addr_hi, addr_lo}. After ale has been high, core_addr[7:0] is the ad_i value seen while ale was high and core_addr[15:8] = addr_hi. This mode is sticky until the filtered reset.
- R5: Each host access produces exactly one request lasting one clock. For a write, core_we = 1 and core_wdata is the ad_i value.
- R6: On a read, ad_oe rises with ad_o equal to the core_rdata returned one cycle after the request. ad_o stays stable while ad_oe is high. ad_oe is low within four cycles of the strobe or chip select negating, and it is never high while core_we = 1.
- R7: On a read, rdy_o rises exactly one clock after ad_oe rises. On a write, rdy_o rises one clock after the request cycle.
- R8: rdy_oe is high only while rdy_en = 1 and an access is in progress. It is low once the access has ended.
- R9: While the filtered reset is active, core_rst_n = 0, ad_oe = 0, rdy_oe = 0 and no request is issued. The reset also clears the multiplexed-address mode.
- R10: A low pulse on rst_raw_n lasting one clock is ignored. A level held for two or more clocks is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_raw_n | input | 1 | Host reset, active low, before filtering |
| cpu_sel | input | 1 | Strap: 1 = separate strobes, 0 = status plus data strobe |
| ctl_a | input | 1 | Write enable (cpu_sel=1) or read/write status (cpu_sel=0) |
| ctl_b | input | 1 | Read enable (cpu_sel=1) or data strobe (cpu_sel=0), active low |
| cs_reg_n | input | 1 | Register-file select, active low |
| cs_mem_n | input | 1 | Buffer-memory select, active low |
| ale | input | 1 | Address latch strobe, active high |
| addr_hi | input | 8 | Upper address byte |
| addr_lo | input | 8 | Lower address byte (split mode) |
| ad_i | input | 8 | Shared address/data bus, input side |
| ad_o | output | 8 | Shared bus read data |
| ad_oe | output | 1 | Shared bus output enable |
| rdy_en | input | 1 | Ready pin enable from configuration |
| rdy_o | output | 1 | Ready value |
| rdy_oe | output | 1 | Ready pin output enable |
| core_rst_n | output | 1 | Filtered reset toward the core |
| core_reg_req | output | 1 | Register-file request, one cycle |
| core_mem_req | output | 1 | Buffer-memory request, one cycle |
| core_we | output | 1 | Request direction, 1 = write |
| core_addr | output | 16 | Request address |
| core_wdata | output | 8 | Request write data |
| core_rdata | input | 8 | Read data, valid the cycle after a request |

## Verification
Several properties are checked on every cycle. Requests last one clock and never target both sides at once. The bus driver is never enabled on a write, and its data stays stable while it is driven. Ready follows the bus enable by one clock. Reset keeps both pad enables low. The bench scenarios cover the rest: how each strap setting decodes the control pins, chip-select priority, split versus multiplexed addressing and the stickiness of that mode, the read data value, the release of the drivers after the strobe negates, and the acceptance or rejection of reset pulses of different lengths.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_LOAD,
    ST_DONE
  } bus_state_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic to_reg;
    logic to_mem;
  } bus_cmd_t;

endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hostbus_rst_filter.sv
// Reset deglitch: the raw level is synchronized, then accepted only when
// HOLD consecutive samples agree. These flops carry no reset of their own.
module hostbus_rst_filter #(
  parameter int SYNC = 2,
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic raw_n,
  output logic rst_n
);

  localparam int LEN = SYNC + HOLD - 1;

  logic [LEN-1:0]  sh_q;
  logic [HOLD-1:0] taps;
  logic            filt_q;
  logic            all_hi, all_lo, upd;

  always_ff @(posedge clk) begin
    sh_q <= {sh_q[LEN-2:0], raw_n};
  end

  assign taps   = sh_q[LEN-1 -: HOLD];
  assign all_hi = &taps;
  assign all_lo = ~|taps;
  assign upd    = (all_hi && !filt_q) || (all_lo && filt_q);

  always_ff @(posedge clk) begin
    if (upd) filt_q <= all_hi;
  end

  assign rst_n = filt_q;

endmodule

// File: rtl/hostbus_decode.sv
module hostbus_decode
  import hostbus_pkg::*;
(
  input  logic     cpu_sel,
  input  logic     ctl_a,
  input  logic     ctl_b,
  input  logic     cs_reg_n,
  input  logic     cs_mem_n,
  output bus_cmd_t cmd
);

  always_comb begin
    if (cpu_sel) begin
      cmd.rd = !ctl_b;
      cmd.wr = !ctl_a && ctl_b;
    end else begin
      cmd.rd = !ctl_b && ctl_a;
      cmd.wr = !ctl_b && !ctl_a;
    end
    cmd.to_reg = !cs_reg_n;
    cmd.to_mem = !cs_mem_n && cs_reg_n;
  end

endmodule

// File: rtl/hostbus_addr.sv
module hostbus_addr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_s,
  input  logic [DW-1:0] ad_s,
  input  logic [DW-1:0] hi_s,
  input  logic [DW-1:0] lo_s,
  output logic [AW-1:0] addr
);

  logic          mux_q;
  logic [DW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= 1'b0;
      lat_q <= '0;
    end else if (ale_s) begin
      mux_q <= 1'b1;
      lat_q <= ad_s;
    end
  end

  assign addr = {hi_s, (mux_q ? lat_q : lo_s)};

endmodule

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
  import hostbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_cmd_t      cmd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata,
  input  logic          rdy_en,
  output logic          req_reg,
  output logic          req_mem,
  output logic          we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          rdy,
  output logic          rdy_oe
);

  bus_state_e    state_q, state_d;
  logic          active, cap_en, load_en, oe_d, rdy_d;
  logic          rd_q, mem_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, dout_q;
  logic          oe_q, rdy_q;

  assign active  = (cmd.rd || cmd.wr) && (cmd.to_reg || cmd.to_mem);
  assign cap_en  = (state_q == ST_IDLE) && active;
  assign load_en = (state_q == ST_WAIT) && active;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (active) state_d = ST_REQ;
      ST_REQ:  if (!active) state_d = ST_IDLE;
               else if (rd_q) state_d = ST_WAIT;
               else state_d = ST_DONE;
      ST_WAIT: state_d = active ? ST_LOAD : ST_IDLE;
      ST_LOAD: state_d = active ? ST_DONE : ST_IDLE;
      ST_DONE: if (!active) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    oe_d  = active && rd_q &&
            ((state_q == ST_WAIT) || (state_q == ST_LOAD) || (state_q == ST_DONE));
    rdy_d = active &&
            ((state_q == ST_LOAD) || (state_q == ST_DONE) ||
             ((state_q == ST_REQ) && !rd_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_q    <= oe_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      mem_q  <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (cap_en) begin
      rd_q   <= cmd.rd;
      mem_q  <= cmd.to_mem;
      addr_q <= addr;
      wd_q   <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (load_en) dout_q <= rdata;
  end

  assign req_reg   = (state_q == ST_REQ) && !mem_q;
  assign req_mem   = (state_q == ST_REQ) && mem_q;
  assign we        = !rd_q;
  assign req_addr  = addr_q;
  assign req_wdata = wd_q;
  assign dout      = dout_q;
  assign dout_oe   = oe_q;
  assign rdy       = rdy_q;
  assign rdy_oe    = rdy_en && (state_q != ST_IDLE);

endmodule

// File: rtl/hostbus_top.sv
module hostbus_top
  import hostbus_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 2
) (
  input  logic          clk,
  input  logic          rst_raw_n,
  input  logic          cpu_sel,
  input  logic          ctl_a,
  input  logic          ctl_b,
  input  logic          cs_reg_n,
  input  logic          cs_mem_n,
  input  logic          ale,
  input  logic [DW-1:0] addr_hi,
  input  logic [DW-1:0] addr_lo,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic          rdy_en,
  output logic          rdy_o,
  output logic          rdy_oe,
  output logic          core_rst_n,
  output logic          core_reg_req,
  output logic          core_mem_req,
  output logic          core_we,
  output logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_wdata,
  input  logic [DW-1:0] core_rdata
);

  localparam int CW = 6;
  localparam int BW = 3 * DW;

  logic            rst_n;
  logic [CW-1:0]   ctl_s;
  logic [BW-1:0]   bus_s;
  logic            sel_s, a_s, b_s, csr_s, csm_s, ale_s;
  logic [DW-1:0]   hi_s, lo_s, ad_s;
  logic [AW-1:0]   addr;
  bus_cmd_t        cmd;

  hostbus_rst_filter #(.SYNC(SYNC_STAGES), .HOLD(RST_HOLD)) u_rst (
    .clk   (clk),
    .raw_n (rst_raw_n),
    .rst_n (rst_n)
  );

  hostbus_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(6'b111110)) u_sync_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cpu_sel, ctl_a, ctl_b, cs_reg_n, cs_mem_n, ale}),
    .q     (ctl_s)
  );

  hostbus_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({addr_hi, addr_lo, ad_i}),
    .q     (bus_s)
  );

  assign {sel_s, a_s, b_s, csr_s, csm_s, ale_s} = ctl_s;
  assign {hi_s, lo_s, ad_s} = bus_s;

  hostbus_decode u_dec (
    .cpu_sel  (sel_s),
    .ctl_a    (a_s),
    .ctl_b    (b_s),
    .cs_reg_n (csr_s),
    .cs_mem_n (csm_s),
    .cmd      (cmd)
  );

  hostbus_addr #(.AW(AW), .DW(DW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ale_s (ale_s),
    .ad_s  (ad_s),
    .hi_s  (hi_s),
    .lo_s  (lo_s),
    .addr  (addr)
  );

  hostbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .addr      (addr),
    .wdata     (ad_s),
    .rdata     (core_rdata),
    .rdy_en    (rdy_en),
    .req_reg   (core_reg_req),
    .req_mem   (core_mem_req),
    .we        (core_we),
    .req_addr  (core_addr),
    .req_wdata (core_wdata),
    .dout      (ad_o),
    .dout_oe   (ad_oe),
    .rdy       (rdy_o),
    .rdy_oe    (rdy_oe)
  );

  assign core_rst_n = rst_n;

endmodule

// File: rtl/hostbus_chk.sv
module hostbus_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic          core_reg_req,
  input logic          core_mem_req,
  input logic          core_we,
  input logic [DW-1:0] ad_o,
  input logic          ad_oe,
  input logic          rdy_o,
  input logic          rdy_oe
);

  a_r3_no_dual_target: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(core_reg_req && core_mem_req));

  a_r5_single_cycle_req: assert property (@(posedge clk) disable iff (!core_rst_n)
    (core_reg_req || core_mem_req) |=> !(core_reg_req || core_mem_req));

  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    ad_oe |-> !core_we);

  a_r6_data_stable: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ad_oe && $past(ad_oe)) |-> $stable(ad_o));

  a_r7_ready_after_drive: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(ad_oe) |=> (rdy_o || !ad_oe));

  a_r9_reset_quiet: assert property (@(posedge clk)
    !core_rst_n |-> (!ad_oe && !rdy_oe && !core_reg_req && !core_mem_req));

endmodule

bind hostbus_top hostbus_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .core_rst_n   (core_rst_n),
  .core_reg_req (core_reg_req),
  .core_mem_req (core_mem_req),
  .core_we      (core_we),
  .ad_o         (ad_o),
  .ad_oe        (ad_oe),
  .rdy_o        (rdy_o),
  .rdy_oe       (rdy_oe)
);

// File: tb/hostbus_top_tb_top.sv
module hostbus_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_raw_n, cpu_sel, ctl_a, ctl_b, cs_reg_n, cs_mem_n, ale, rdy_en;
  logic [7:0]  addr_hi, addr_lo, ad_i, ad_o, core_wdata;
  logic [7:0]  core_rdata = 8'h00;
  logic        ad_oe, rdy_o, rdy_oe, core_rst_n, core_reg_req, core_mem_req, core_we;
  logic [15:0] core_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          n_reg = 0, n_mem = 0;
  logic [15:0] last_addr = 16'h0;
  logic [7:0]  last_wd = 8'h0;
  logic        last_we = 1'b0;

  always #10 clk = ~clk;

  hostbus_top dut_i (
    .clk(clk), .rst_raw_n(rst_raw_n), .cpu_sel(cpu_sel), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .cs_reg_n(cs_reg_n), .cs_mem_n(cs_mem_n), .ale(ale), .addr_hi(addr_hi),
    .addr_lo(addr_lo), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .rdy_en(rdy_en),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe), .core_rst_n(core_rst_n), .core_reg_req(core_reg_req),
    .core_mem_req(core_mem_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata)
  );

  function automatic logic [7:0] model_rd(input logic mem, input logic [15:0] a);
    return mem ? (a[15:8] ^ ~a[7:0]) : (a[7:0] + 8'h31);
  endfunction

  // core-side model: registered read data, request log
  always @(posedge clk) begin
    if (core_reg_req || core_mem_req) begin
      if (core_reg_req) n_reg <= n_reg + 1;
      if (core_mem_req) n_mem <= n_mem + 1;
      last_addr <= core_addr;
      last_wd   <= core_wdata;
      last_we   <= core_we;
      if (!core_we) core_rdata <= model_rd(core_mem_req, core_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    ctl_a = 1'b1; ctl_b = 1'b1; cs_reg_n = 1'b1; cs_mem_n = 1'b1; ale = 1'b0;
  endtask

  task automatic do_access(input bit rd, input bit sr, input bit sm,
                           input logic [15:0] a, input logic [7:0] wd,
                           output logic [7:0] got, output int oe_at,
                           output int rdy_at, output bit roe_seen);
    @(negedge clk);
    addr_hi = a[15:8]; addr_lo = a[7:0]; ad_i = rd ? 8'h00 : wd;
    cs_reg_n = !sr; cs_mem_n = !sm;
    if (cpu_sel) begin ctl_a = rd; ctl_b = !rd; end
    else begin ctl_a = rd; ctl_b = 1'b0; end
    oe_at = -1; rdy_at = -1; roe_seen = 0; got = 8'h00;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (ad_oe && oe_at < 0) oe_at = i;
      if (rdy_o && rdy_at < 0) rdy_at = i;
      if (rdy_oe) roe_seen = 1;
    end
    got = ad_o;
    idle_bus();
    repeat (4) @(negedge clk);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_raw_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_raw_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_raw_n = 1'b0; cpu_sel = 1'b1; rdy_en = 1'b1;
    addr_hi = 8'h00; addr_lo = 8'h00; ad_i = 8'h00;
    idle_bus();
    repeat (6) @(negedge clk);
    chk(core_rst_n == 1'b0, "R9", "core_rst_n in reset", core_rst_n, 0);
    chk(!ad_oe && !rdy_oe, "R9", "pad enables in reset", {ad_oe, rdy_oe}, 0);
    rst_raw_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(core_rst_n == 1'b1, "R10", "reset released", core_rst_n, 1);
    chk(n_reg + n_mem == 0, "R9", "no request around reset", n_reg + n_mem, 0);
    chk(rdy_oe == 1'b0, "R8", "ready idle", rdy_oe, 0);
  endtask

  task automatic t_sep_read_reg();
    logic [7:0] got; int oe_at, rdy_at; bit roe; int r0 = n_reg;
    cpu_sel = 1'b1;
    do_access(1, 1, 0, 16'h0A5C, 8'h00, got, oe_at, rdy_at, roe);
    chk(n_reg == r0 + 1, "R5", "one reg request", n_reg - r0, 1);
    chk(last_we == 1'b0, "R1", "read decoded", last_we, 0);
    chk(last_addr == 16'h0A5C, "R4", "split address", last_addr, 16'h0A5C);
    chk(got == model_rd(0, 16'h0A5C), "R6", "read data", got, model_rd(0, 16'h0A5C));
    chk(oe_at == 5, "R6", "drive cycle", oe_at, 5);
    chk(rdy_at == oe_at + 1, "R7", "ready one after drive", rdy_at, oe_at + 1);
    chk(roe, "R8", "ready enabled during access", roe, 1);
    chk(!ad_oe && !rdy_oe, "R6", "release after strobe", {ad_oe, rdy_oe}, 0);
  endtask

  task automatic t_sep_write_mem();
    logic [7:0] got; int oe_at, rdy_at; bit roe; int m0 = n_mem;
    cpu_sel = 1'b1;
    do_access(0, 0, 1, 16'hBEEF, 8'h3C, got, oe_at, rdy_at, roe);
    chk(n_mem == m0 + 1, "R3", "mem request", n_mem - m0, 1);
    chk(last_we == 1'b1, "R1", "write decoded", last_we, 1);
    chk(last_wd == 8'h3C, "R5", "write data", last_wd, 8'h3C);
    chk(oe_at == -1, "R6", "no drive on write", oe_at, -1);
    chk(rdy_at == 4, "R7", "write ready cycle", rdy_at, 4);
  endtask

  task automatic t_strobe_mode();
    logic [7:0] got; int oe_at, rdy_at; bit roe; int m0 = n_mem; int r0 = n_reg;
    cpu_sel = 1'b0;
    do_access(1, 0, 1, 16'h7F21, 8'h00, got, oe_at, rdy_at, roe);
    chk(n_mem == m0 + 1 && last_we == 1'b0, "R2", "status-high read", last_we, 0);
    chk(got == model_rd(1, 16'h7F21), "R2", "mem read data", got, model_rd(1, 16'h7F21));
    chk(rdy_at == oe_at + 1, "R7", "ready after drive", rdy_at, oe_at + 1);
    do_access(0, 1, 0, 16'h0033, 8'hA7, got, oe_at, rdy_at, roe);
    chk(n_reg == r0 + 1 && last_we == 1'b1, "R2", "status-low write", last_we, 1);
    chk(last_wd == 8'hA7, "R2", "write data", last_wd, 8'hA7);
    cpu_sel = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_both_cs();
    logic [7:0] got; int oe_at, rdy_at; bit roe; int m0 = n_mem; int r0 = n_reg;
    do_access(1, 1, 1, 16'h4411, 8'h00, got, oe_at, rdy_at, roe);
    chk(n_reg == r0 + 1, "R3", "register wins", n_reg - r0, 1);
    chk(n_mem == m0, "R3", "memory suppressed", n_mem - m0, 0);
    chk(got == model_rd(0, 16'h4411), "R3", "register data", got, model_rd(0, 16'h4411));
  endtask

  task automatic t_rdy_disabled();
    logic [7:0] got; int oe_at, rdy_at; bit roe;
    rdy_en = 1'b0;
    do_access(1, 0, 1, 16'h1234, 8'h00, got, oe_at, rdy_at, roe);
    chk(roe == 0, "R8", "ready pin undriven when disabled", roe, 0);
    chk(got == model_rd(1, 16'h1234), "R6", "read still served", got, model_rd(1, 16'h1234));
    rdy_en = 1'b1;
  endtask

  task automatic t_mux_addr();
    logic [7:0] got; int oe_at, rdy_at; bit roe;
    @(negedge clk); ad_i = 8'hC3; ale = 1'b1;
    repeat (2) @(negedge clk); ale = 1'b0;
    @(negedge clk);
    do_access(0, 1, 0, 16'h1277, 8'h5E, got, oe_at, rdy_at, roe);
    chk(last_addr == 16'h12C3, "R4", "latched low byte", last_addr, 16'h12C3);
    do_access(1, 0, 1, 16'h9901, 8'h00, got, oe_at, rdy_at, roe);
    chk(last_addr == 16'h99C3, "R4", "mux mode sticky", last_addr, 16'h99C3);
    hard_reset();
    do_access(0, 1, 0, 16'h1277, 8'h11, got, oe_at, rdy_at, roe);
    chk(last_addr == 16'h1277, "R9", "reset clears mux mode", last_addr, 16'h1277);
  endtask

  task automatic t_deglitch();
    int c0;
    @(negedge clk);
    addr_hi = 8'h20; addr_lo = 8'h08; cs_reg_n = 1'b0; ctl_a = 1'b1; ctl_b = 1'b0;
    repeat (8) @(negedge clk);
    chk(ad_oe == 1'b1, "R6", "read held driving", ad_oe, 1);
    rst_raw_n = 1'b0;
    @(negedge clk);
    rst_raw_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(core_rst_n == 1'b1, "R10", "glitch ignored", core_rst_n, 1);
    chk(ad_oe == 1'b1, "R10", "drive kept after glitch", ad_oe, 1);
    c0 = n_reg + n_mem;
    rst_raw_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_raw_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(core_rst_n == 1'b0, "R10", "two-cycle pulse accepted", core_rst_n, 0);
    chk(!ad_oe && !rdy_oe, "R9", "drivers off in reset", {ad_oe, rdy_oe}, 0);
    idle_bus();
    repeat (6) @(negedge clk);
    chk(core_rst_n == 1'b1, "R10", "reset release accepted", core_rst_n, 1);
    chk(n_reg + n_mem == c0, "R9", "no request through reset", n_reg + n_mem, c0);
  endtask

  initial begin
    t_reset();
    t_sep_read_reg();
    t_sep_write_mem();
    t_strobe_mode();
    t_both_cs();
    t_rdy_disabled();
    t_mux_addr();
    t_deglitch();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule